// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps a 14-bit virtual address onto a 16-bit physical address through a four-entry segment table that belongs to the running process. The two top address bits pick an entry. The remaining twelve bits are an offset. The offset is added to the entry's base, and at the same time it is compared against the entry's limit. An access whose offset is not below the limit, or whose entry is not marked valid, produces a fault rather than an address.

Privileged software loads the table through a write port. One write carries an entry index, a base, a limit and a valid flag. On a context switch, software rewrites all four entries. The translation port takes a request in one cycle and returns the registered result in the next cycle. The virtual address of the most recent faulting request is held in a status register so that a handler can read it.

Top module: `seg_xlate_unit`

## Requirements
- R1: Virtual address bits [13:12] select the table entry, and bits [11:0] are the offset.
- R2: For a legal access, the physical address is the entry base plus the zero-extended offset, taken modulo 2^16.
- R3: An access faults when its offset is greater than or equal to the entry limit. The limit is 13 bits wide, so a limit of 0 always faults and a limit of 4096 admits every offset.
- R4: An access to an entry whose valid flag is clear faults, whatever its offset. Reset clears every valid flag.
- R5: rspValid is high in exactly the cycle after a cycle with reqValid high, and rspPa and rspFault belong to that request.
- R6: When rspFault is high, rspPa is zero.
- R7: faultVa takes the virtual address of a faulting request in the same cycle that rspFault rises for it. It keeps its value otherwise and is zero after reset.
- R8: A table write is seen by requests from the following cycle onward. A request in the same cycle as a write to its entry uses the old contents.
- R9: When rspValid is low, rspPa and rspFault are zero.
- R10: A write replaces the base, the limit and the valid flag of its entry together and leaves the other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Table write strobe (privileged) |
| tblWrIdx | input | 2 | Entry index to write |
| tblWrBase | input | 16 | New segment base |
| tblWrLimit | input | 13 | New segment limit (offsets below it are legal) |
| tblWrValid | input | 1 | New valid flag |
| reqValid | input | 1 | Translation request strobe |
| reqVa | input | 14 | Virtual address to translate |
| rspValid | output | 1 | Result is present this cycle |
| rspPa | output | 16 | Translated physical address, zero on fault |
| rspFault | output | 1 | Access trapped |
| faultVa | output | 14 | Virtual address of the last faulting request |

## Verification
On every cycle, the assertions check the response timing, the zeroed address on a fault, the idle output values, and the rule that faultVa moves only together with a fault. They also check that an invalid entry or an out-of-range offset leads to a fault in the next cycle. Only the bench scenarios can show that the arithmetic is correct against chosen bases, including wrap past the top of physical memory. The same holds for the exact edges of the limit (limit minus one, the limit itself, zero and 4096), the old-versus-new contents when a request meets a write, and a full table reload that replaces a previous process's mapping.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic loadRsp;     // capture a translation result
    logic clearRsp;    // drive idle response values
    logic latchFault;  // record the faulting virtual address
  } segStrobe_t;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_BITS   = 2,
  parameter int PA_BITS    = 16,
  parameter int LIMIT_BITS = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [SEG_BITS-1:0]   wrIdx,
  input  logic [PA_BITS-1:0]    wrBase,
  input  logic [LIMIT_BITS-1:0] wrLimit,
  input  logic                  wrValid,
  input  logic [SEG_BITS-1:0]   rdIdx,
  output logic [PA_BITS-1:0]    rdBase,
  output logic [LIMIT_BITS-1:0] rdLimit,
  output logic                  rdValid
);
  localparam int NUM_SEG = 1 << SEG_BITS;

  logic [PA_BITS-1:0]    baseQ  [NUM_SEG];
  logic [LIMIT_BITS-1:0] limitQ [NUM_SEG];
  logic [NUM_SEG-1:0]    validQ;

  for (genvar e = 0; e < NUM_SEG; e++) begin : gEntry
    logic hitWr;
    assign hitWr = wrEn && (wrIdx == SEG_BITS'(e));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[e]  <= '0;
        limitQ[e] <= '0;
        validQ[e] <= 1'b0;
      end else if (hitWr) begin
        baseQ[e]  <= wrBase;
        limitQ[e] <= wrLimit;
        validQ[e] <= wrValid;
      end
    end
  end

  // The read is combinational, so a same-cycle write is not yet visible.
  assign rdBase  = baseQ[rdIdx];
  assign rdLimit = limitQ[rdIdx];
  assign rdValid = validQ[rdIdx];

  // R10
  wr_valid_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (validQ[$past(wrIdx)] == $past(wrValid)));

  // R10
  wr_limit_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (limitQ[$past(wrIdx)] == $past(wrLimit)));

endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       xlateFault,
  output segStrobe_t strobe,
  output logic       rspValid
);
  always_comb begin
    strobe            = '0;
    strobe.loadRsp    = reqValid;
    strobe.clearRsp   = !reqValid;
    strobe.latchFault = reqValid && xlateFault;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  // R5
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R5
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R5
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadRsp, strobe.clearRsp}));

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_xlate_pkg::*;
#(
  parameter int SEG_BITS   = 2,
  parameter int OFF_BITS   = 12,
  parameter int PA_BITS    = 16,
  parameter int LIMIT_BITS = OFF_BITS + 1,
  parameter int VA_BITS    = SEG_BITS + OFF_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  segStrobe_t            strobe,
  input  logic [VA_BITS-1:0]    reqVa,
  input  logic [PA_BITS-1:0]    entBase,
  input  logic [LIMIT_BITS-1:0] entLimit,
  input  logic                  entValid,
  output logic [SEG_BITS-1:0]   segIdx,
  output logic                  xlateFault,
  output logic [PA_BITS-1:0]    rspPa,
  output logic                  rspFault,
  output logic [VA_BITS-1:0]    faultVa
);
  localparam int PAD_BITS  = PA_BITS - OFF_BITS;
  localparam int LPAD_BITS = LIMIT_BITS - OFF_BITS;

  logic [OFF_BITS-1:0] offset;
  logic [PA_BITS-1:0]  sumPa;
  logic                inRange;

  assign segIdx = reqVa[VA_BITS-1 -: SEG_BITS];
  assign offset = reqVa[OFF_BITS-1:0];

  // Add and compare side by side; neither waits on the other.
  assign sumPa      = entBase + {{PAD_BITS{1'b0}}, offset};
  assign inRange    = {{LPAD_BITS{1'b0}}, offset} < entLimit;
  assign xlateFault = !entValid || !inRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPa    <= '0;
      rspFault <= 1'b0;
    end else if (strobe.loadRsp) begin
      rspPa    <= xlateFault ? '0 : sumPa;
      rspFault <= xlateFault;
    end else if (strobe.clearRsp) begin
      rspPa    <= '0;
      rspFault <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  faultVa <= '0;
    else if (strobe.latchFault) faultVa <= reqVa;
  end

  // R6
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspPa == '0));

  // R4
  invalid_seg_faults_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRsp && !entValid) |=> rspFault);

  // R3
  over_limit_faults_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRsp && ({{LPAD_BITS{1'b0}}, offset} >= entLimit)) |=> rspFault);

  // R7
  fault_va_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspFault) |-> (faultVa == $past(reqVa)));

  // R7
  fault_va_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspFault |-> $stable(faultVa));

  // R9
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearRsp |=> (!rspFault && rspPa == '0));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_BITS   = 2,
  parameter int OFF_BITS   = 12,
  parameter int PA_BITS    = 16,
  parameter int VA_BITS    = SEG_BITS + OFF_BITS,
  parameter int LIMIT_BITS = OFF_BITS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tblWrEn,
  input  logic [SEG_BITS-1:0]   tblWrIdx,
  input  logic [PA_BITS-1:0]    tblWrBase,
  input  logic [LIMIT_BITS-1:0] tblWrLimit,
  input  logic                  tblWrValid,
  input  logic                  reqValid,
  input  logic [VA_BITS-1:0]    reqVa,
  output logic                  rspValid,
  output logic [PA_BITS-1:0]    rspPa,
  output logic                  rspFault,
  output logic [VA_BITS-1:0]    faultVa
);
  segStrobe_t            strobe;
  logic [SEG_BITS-1:0]   segIdx;
  logic [PA_BITS-1:0]    entBase;
  logic [LIMIT_BITS-1:0] entLimit;
  logic                  entValid;
  logic                  xlateFault;

  seg_table #(.SEG_BITS(SEG_BITS), .PA_BITS(PA_BITS), .LIMIT_BITS(LIMIT_BITS)) uTable (
    .clk(clk), .rstN(rstN),
    .wrEn(tblWrEn), .wrIdx(tblWrIdx), .wrBase(tblWrBase),
    .wrLimit(tblWrLimit), .wrValid(tblWrValid),
    .rdIdx(segIdx), .rdBase(entBase), .rdLimit(entLimit), .rdValid(entValid)
  );

  seg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .xlateFault(xlateFault),
    .strobe(strobe), .rspValid(rspValid)
  );

  seg_datapath #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS),
                 .LIMIT_BITS(LIMIT_BITS), .VA_BITS(VA_BITS)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVa(reqVa),
    .entBase(entBase), .entLimit(entLimit), .entValid(entValid),
    .segIdx(segIdx), .xlateFault(xlateFault),
    .rspPa(rspPa), .rspFault(rspFault), .faultVa(faultVa)
  );

endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        tblWrEn;
  logic [1:0]  tblWrIdx;
  logic [15:0] tblWrBase;
  logic [12:0] tblWrLimit;
  logic        tblWrValid;
  logic        reqValid;
  logic [13:0] reqVa;
  logic        rspValid;
  logic [15:0] rspPa;
  logic        rspFault;
  logic [13:0] faultVa;

  always #2 clk = ~clk;  // 250 MHz

  seg_xlate_unit uut (
    .clk(clk), .rstN(rstN),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrBase(tblWrBase),
    .tblWrLimit(tblWrLimit), .tblWrValid(tblWrValid),
    .reqValid(reqValid), .reqVa(reqVa),
    .rspValid(rspValid), .rspPa(rspPa), .rspFault(rspFault), .faultVa(faultVa)
  );

  // Behavioural reference state
  int mBase [4];
  int mLimit[4];
  bit mValid[4];
  int eValid, ePa, eFault, eFva;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic compare(string tag);
    checks++;
    if (rspValid !== 1'(eValid) || rspPa !== 16'(ePa) ||
        rspFault !== 1'(eFault) || faultVa !== 14'(eFva)) begin
      fails++;
      $display("FAIL %s: got v=%0d pa=%h f=%0d fva=%h exp v=%0d pa=%h f=%0d fva=%h",
               tag, rspValid, rspPa, rspFault, faultVa, eValid, ePa[15:0], eFault, eFva[13:0]);
    end
  endtask

  // One cycle: drive, let the edge pass, update the model, compare at negedge.
  task automatic cyc(bit we, int idx, int base, int lim, bit vld,
                     bit rv, int va, string tag);
    int seg, off;
    tblWrEn = we; tblWrIdx = 2'(idx); tblWrBase = 16'(base);
    tblWrLimit = 13'(lim); tblWrValid = vld;
    reqValid = rv; reqVa = 14'(va);
    @(posedge clk);
    seg = (va >> 12) & 3;
    off = va & 'hFFF;
    eValid = rv;
    if (rv) begin
      eFault = (!mValid[seg] || off >= mLimit[seg]) ? 1 : 0;
      ePa    = eFault ? 0 : ((mBase[seg] + off) & 'hFFFF);
      if (eFault) eFva = va & 'h3FFF;
    end else begin
      eFault = 0;
      ePa    = 0;
    end
    if (we) begin
      mBase[idx] = base & 'hFFFF; mLimit[idx] = lim & 'h1FFF; mValid[idx] = vld;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic req(int va, string tag);
    cyc(0, 0, 0, 0, 0, 1, va, tag);
  endtask

  task automatic wr(int idx, int base, int lim, bit vld, string tag);
    cyc(1, idx, base, lim, vld, 0, 0, tag);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mBase[i] = 0; mLimit[i] = 0; mValid[i] = 0; end
    eValid = 0; ePa = 0; eFault = 0; eFva = 0;
    rstN = 0; tblWrEn = 0; tblWrIdx = 0; tblWrBase = 0; tblWrLimit = 0;
    tblWrValid = 0; reqValid = 0; reqVa = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R9 reset");
    rstN = 1;

    // R4: all entries invalid after reset
    for (int s = 0; s < 4; s++) req((s << 12) | 'h010, "R4 invalid after reset");
    cyc(0, 0, 0, 0, 0, 0, 0, "R9 idle");

    // R8: request meets write to its own entry -> old (invalid) contents
    cyc(1, 0, 'h2000, 'h500, 1, 1, 'h0100, "R8 same-cycle old entry");
    req('h0100, "R8 next-cycle new entry");

    wr(1, 'h8000, 'h1000, 1, "R10 load seg1");
    wr(2, 'hF800, 'h900, 1, "R10 load seg2");
    wr(3, 'h1234, 'h100, 0, "R10 load seg3 invalid");

    // R1/R2 translations across segments
    req('h0000, "R2 seg0 base");
    req('h04FF, "R3 seg0 limit-1");
    req('h0500, "R3 seg0 at limit");
    req('h1FFF, "R3 seg1 limit 4096 max offset");
    req('h1ABC, "R1 seg1 offset");
    req('h27FF, "R2 seg2 below wrap");
    req('h2800, "R2 seg2 wraps modulo");
    req('h2900, "R3 seg2 at limit");
    req('h3000, "R4 seg3 invalid offset 0");
    cyc(0, 0, 0, 0, 0, 0, 0, "R7 hold while idle");
    req('h0004, "R7 legal keeps faultVa");

    // R3: zero limit always faults
    wr(0, 'h0100, 0, 1, "R10 zero limit");
    req('h0000, "R3 zero limit faults");

    // R10: context switch rewrites table; other entries intact first
    req('h1010, "R10 seg1 untouched");
    wr(0, 'h4000, 'hFFF, 1, "R10 reload seg0");
    wr(1, 0, 'h200, 0, "R10 reload seg1");
    wr(2, 'h7000, 'h1, 1, "R10 reload seg2");
    wr(3, 'hC000, 'h800, 1, "R10 reload seg3");
    req('h0FFE, "R10 seg0 new");
    req('h0FFF, "R3 seg0 limit 0xFFF");
    req('h1000, "R10 seg1 now invalid");
    req('h2000, "R2 seg2 limit 1 legal");
    req('h2001, "R3 seg2 limit 1 fault");
    req('h37FF, "R2 seg3 new");

    // R5: back-to-back and gaps
    cyc(0, 0, 0, 0, 0, 0, 0, "R5 no request");
    cyc(1, 3, 'hC100, 'h800, 1, 1, 'h3010, "R8 same-cycle old base");
    req('h3010, "R8 new base visible");
    cyc(0, 0, 0, 0, 0, 0, 0, "R9 idle after");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule